// File: doc/BRIEF.md
# Handshake-Gated Stream Tally Pipeline

This block sits in the middle of a streaming data path, with an AXI4-Stream receiver on one side and an AXI4-Stream transmitter on the other. It carries the valid, ready and last signals across unchanged. Only the data word goes through a fixed-depth register pipeline. The pipeline moves one step only in a cycle where a transfer takes place, meaning the input valid and the output-side ready are both high. Each input record is therefore taken into the pipeline exactly once, and its result comes out a fixed number of transfers later.

Each record holds a 32-bit duration. A stand-in pricing stage multiplies the duration by a constant rate. A final stage keeps a running total of these per-record costs. The pipeline has no occupancy bits, so it starts out full of zeros. A producer that wants every result must append as many zero records as the pipeline is deep. Zero records cost nothing and leave the total unchanged.

Top module: `stream_tally_pipe`

## Requirements
- R1: The pipeline, including the output data, advances only in a cycle where s_tvalid and m_tready are both high. A cycle with only one of them high changes nothing.
- R2: m_tvalid equals s_tvalid, s_tready equals m_tready, and m_tlast equals s_tlast, in the same cycle and with no register between them.
- R3: With DEPTH = 11, the output beat with index k (counted from reset, transfers only) carries the cost of input beat k-11 in m_tdata[31:0].
- R4: The first 11 output beats after reset carry zero cost and zero total.
- R5: The duration is s_tdata[31:0]. Bits s_tdata[63:32] are ignored. The cost is the low 32 bits of duration × RATE (default RATE = 7).
- R6: m_tdata[63:32] holds the running total, modulo 2^32, of every cost shown so far in m_tdata[31:0], including the current beat's cost.
- R7: A zero-duration record adds nothing to the total. After 11 zero records are appended, one more beat shows the total of all real records.
- R8: An active-low asynchronous reset clears every stage and the total, so m_tdata reads zero while reset is held.
- R9: While no transfer takes place, m_tdata holds its value for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the receiving stream interface |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| s_tdata | input | 64 | Input record; the duration is in bits 31:0 |
| s_tvalid | input | 1 | Input valid, passed to m_tvalid |
| s_tready | output | 1 | Input ready, taken from m_tready |
| s_tlast | input | 1 | Input end-of-packet, passed to m_tlast |
| m_tdata | output | 64 | {running total, cost} from the last pipeline stage |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output-side ready |
| m_tlast | output | 1 | Output end-of-packet |

## Verification
The bench builds the block with its default parameters: a 64-bit word, a depth of 11 and a rate of 7. With these values, full-range random durations drive both the 32-bit cost product and the 32-bit total past their wrap points. A depth of 11 also makes the zero-filled start-up window and the 11-record flush long enough to check beat by beat. Random valid and ready patterns, together with long one-sided stalls, show whether a beat is ever skipped or taken twice.

// File: rtl/stream_tally_pkg.sv
package stream_tally_pkg;
  localparam int unsigned TALLY_DATA_W = 64;
  localparam int unsigned TALLY_DEPTH  = 11;
  localparam int unsigned TALLY_RATE   = 7;
endpackage

// File: rtl/tally_cost_stage.sv
module tally_cost_stage #(
  parameter int unsigned W    = 32,
  parameter int unsigned RATE = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] dur,
  output logic [W-1:0] cost_q
);
  localparam logic [W-1:0] RATE_V = W'(RATE);

  logic [W-1:0] cost_d;

  always_comb begin
    cost_d = cost_q;
    if (en) cost_d = dur * RATE_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cost_q <= '0;
    else        cost_q <= cost_d;
  end

  // R7: a zero record enters as zero cost
  p_zero_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dur == '0) |=> (cost_q == '0));
endmodule

// File: rtl/tally_delay_line.sv
module tally_delay_line #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  if (N == 0) begin : g_wire
    assign dout = din;
  end else begin : g_regs
    logic [W-1:0] q [N];
    logic [W-1:0] d [N];
    for (genvar i = 0; i < N; i++) begin : g_stage
      logic [W-1:0] src;
      if (i == 0) begin : g_head
        assign src = din;
      end else begin : g_tail
        assign src = q[i-1];
      end
      always_comb begin
        d[i] = q[i];
        if (en) d[i] = src;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= '0;
        else        q[i] <= d[i];
      end
    end
    assign dout = q[N-1];

    // R9: the chain is frozen while no transfer happens
    p_chain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(dout));
  end
endmodule

// File: rtl/tally_total_stage.sv
module tally_total_stage #(
  parameter int unsigned COST_W = 32,
  parameter int unsigned ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [COST_W-1:0] cost_in,
  output logic [COST_W-1:0] cost_q,
  output logic [ACC_W-1:0]  acc_q
);
  logic [COST_W-1:0] cost_d;
  logic [ACC_W-1:0]  acc_d;

  always_comb begin
    cost_d = cost_q;
    acc_d  = acc_q;
    if (en) begin
      cost_d = cost_in;
      acc_d  = acc_q + ACC_W'(cost_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_q <= '0;
      acc_q  <= '0;
    end else begin
      cost_q <= cost_d;
      acc_q  <= acc_d;
    end
  end

  // R6: the total grows by exactly the cost that is now shown
  p_acc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (acc_q == $past(acc_q) + ACC_W'(cost_q)));
  // R1: no transfer, no change to the total
  p_acc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/stream_tally_pipe.sv
module stream_tally_pipe
  import stream_tally_pkg::*;
#(
  parameter int unsigned DATA_W = TALLY_DATA_W,
  parameter int unsigned DEPTH  = TALLY_DEPTH,
  parameter int unsigned RATE   = TALLY_RATE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast
);
  localparam int unsigned COST_W = DATA_W / 2;
  localparam int unsigned ACC_W  = DATA_W - COST_W;
  localparam int unsigned MID    = DEPTH - 2;

  logic              adv;
  logic [COST_W-1:0] cost_head;
  logic [COST_W-1:0] cost_tail;
  logic [COST_W-1:0] cost_out;
  logic [ACC_W-1:0]  acc_out;
  logic              unused_hi;

  assign adv      = s_tvalid & m_tready;
  assign s_tready = m_tready;
  assign m_tvalid = s_tvalid;
  assign m_tlast  = s_tlast;
  assign unused_hi = ^s_tdata[DATA_W-1:COST_W];

  tally_cost_stage #(.W(COST_W), .RATE(RATE)) u_cost (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .dur(s_tdata[COST_W-1:0]), .cost_q(cost_head)
  );

  tally_delay_line #(.W(COST_W), .N(MID)) u_delay (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .din(cost_head), .dout(cost_tail)
  );

  tally_total_stage #(.COST_W(COST_W), .ACC_W(ACC_W)) u_total (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .cost_in(cost_tail), .cost_q(cost_out), .acc_q(acc_out)
  );

  assign m_tdata = {acc_out, cost_out};

  // R1: output word moves only on a real transfer
  p_out_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_tvalid && m_tready) |=> $stable(m_tdata));
  // R8: reset holds the output word at zero
  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |-> (m_tdata == '0));
endmodule

// File: tb/tb_stream_tally_pipe.sv
module tb_stream_tally_pipe;
  localparam int unsigned DEPTH = 11;
  localparam int unsigned RATE  = 7;

  logic        clk;
  logic        rst_n;
  logic [63:0] s_tdata;
  logic        s_tvalid;
  logic        s_tready;
  logic        s_tlast;
  logic [63:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready;
  logic        m_tlast;

  int          n_chk;
  int          n_bad;
  int          n_beat;
  logic [31:0] cost_hist [4096];
  logic [31:0] exp_acc;
  logic [31:0] real_sum;
  bit          prev_beat;
  logic [63:0] prev_data;

  stream_tally_pipe dut (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] price(input logic [31:0] dur);
    logic [63:0] p;
    p = {32'd0, dur} * 64'(RATE);
    return p[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    n_beat    = 0;
    exp_acc   = '0;
    real_sum  = '0;
    prev_beat = 1'b1;
  endtask

  task automatic step(input logic v, input logic r, input logic l, input logic [63:0] d);
    logic [31:0] ec;
    @(negedge clk);
    s_tvalid = v; m_tready = r; s_tlast = l; s_tdata = d;
    #1;
    chk(m_tvalid == v && s_tready == r && m_tlast == l, "R2", "pass-through",
        {61'd0, m_tvalid, s_tready, m_tlast}, {61'd0, v, r, l});
    if (!prev_beat) begin
      if (v ^ r) chk(m_tdata == prev_data, "R1", "one-sided handshake moved data", m_tdata, prev_data);
      else       chk(m_tdata == prev_data, "R9", "idle cycle moved data", m_tdata, prev_data);
    end
    if (v && r) begin
      ec = '0;
      if (n_beat >= DEPTH) ec = cost_hist[n_beat - DEPTH];
      exp_acc = exp_acc + ec;
      if (n_beat < DEPTH)
        chk(m_tdata == 64'd0, "R4", "start-up beat not zero", m_tdata, 64'd0);
      else begin
        chk(m_tdata[31:0] == ec, "R3", "cost lag", {32'd0, m_tdata[31:0]}, {32'd0, ec});
        chk(m_tdata[63:32] == exp_acc, "R6", "running total", {32'd0, m_tdata[63:32]}, {32'd0, exp_acc});
      end
      cost_hist[n_beat] = price(d[31:0]);
      real_sum = real_sum + price(d[31:0]);
      n_beat++;
    end
    prev_beat = v && r;
    prev_data = m_tdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", n_beat, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0171));
    n_chk = 0; n_bad = 0;
    s_tvalid = 0; m_tready = 0; s_tlast = 0; s_tdata = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 chk(m_tdata == 64'd0, "R8", "reset state", m_tdata, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // R4/R3/R6: directed beats, then random handshakes with junk upper bits (R5)
    for (int i = 0; i < 5; i++) step(1, 1, 0, {32'hFFFF_FFFF, 32'(i + 1)});
    step(1, 1, 0, {32'hABCD_0123, 32'hFFFF_FFFF});   // R5 product wraps
    step(1, 1, 0, {32'hFFFF_FFFF, 32'h0});           // R5 upper ignored
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           {$urandom, $urandom});

    // R9/R1: long one-sided stalls
    for (int i = 0; i < 40; i++) step(1, 0, 1, {$urandom, $urandom});
    for (int i = 0; i < 40; i++) step(0, 1, 0, {$urandom, $urandom});
    for (int i = 0; i < 20; i++) step(0, 0, 0, '0);

    // R7: pad with zero records, then one more beat shows the whole total
    for (int i = 0; i < DEPTH; i++) step(1, 1, i == DEPTH - 1, {$urandom, 32'h0});
    step(1, 1, 0, 64'd0);
    chk(m_tdata[63:32] == real_sum, "R7", "flushed total", {32'd0, m_tdata[63:32]}, {32'd0, real_sum});
    step(1, 1, 0, 64'd0);
    chk(m_tdata[63:32] == real_sum, "R7", "zero record changed total", {32'd0, m_tdata[63:32]}, {32'd0, real_sum});

    // R8: asynchronous reset in the middle of a cycle
    @(negedge clk);
    #3 rst_n = 1'b0;
    #2 chk(m_tdata == 64'd0, "R8", "mid-run reset", m_tdata, 64'd0);
    @(negedge clk) rst_n = 1'b1;
    model_reset();
    for (int i = 0; i < 30; i++) step(1, 1, 0, {$urandom, $urandom});
    for (int i = 0; i < DEPTH + 1; i++) step(1, 1, 0, 64'd0);
    chk(m_tdata[63:32] == real_sum, "R7", "second flush", {32'd0, m_tdata[63:32]}, {32'd0, real_sum});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule